// File: doc/BRIEF.md
# Dual-Channel Staged-Register PWM Generator

This block produces two independent pulse-width-modulated outputs from a single input clock. Software programs each channel through four word registers on a simple synchronous register bus: a control word, a prescaler, a period and a duty value. Each channel divides the clock by (prescaler+1). It counts the divided ticks from 0 up to the period value and drives its output high while the count is below the duty value. One output period therefore lasts (prescaler+1)×(period+1) clock cycles.

No register write acts at once. Each value first waits in a staging slot for a fixed synchronization delay and then moves into the register's holding copy. While a transfer is outstanding, a busy flag for that register and channel is visible in a shared read-only status word. Software polls this word before it issues dependent writes. The counter logic runs from a separate set of active values. These follow the holding copies either straight away or only at a period boundary (autoload), and control strobes can force an early load. Disabling a channel either lets the current period finish or stops the counter at once.

Top module: `pwm2_top`

## Requirements
- R1: Channel c owns byte addresses c×0x10 to c×0x10+0xF, with the control word at +0x0, the prescaler at +0x4, the period at +0x8 and the duty at +0xC. A read returns the register's holding copy, zero-extended. Bits above a field's width are dropped: the control word is 6 bits, the prescaler 10 bits, and period and duty 12 bits each.
- R2: A write sets that register's busy flag after the clock edge that samples it. Two edges later the value reaches the holding copy and the busy flag clears on that same edge. Until then, a read still returns the previous value.
- R3: The status word at address 0x40 holds channel c's flags in bits c×8+3 down to c×8: bit 0 is control, bit 1 prescaler, bit 2 period and bit 3 duty. A write to address 0x40 changes nothing.
- R4: Windows 0x20 and 0x30, and any address above 0x40, read as zero. Writes to them set no busy flag and change no register.
- R5: A running channel outputs a waveform with a period of (prescaler+1)×(period+1) cycles. The output is high for (prescaler+1)×min(duty, period+1) of those cycles. A duty of 0 keeps it low.
- R6: Control bit 1 complements the output, both while the channel runs and while it is parked.
- R7: When control bit 2 (autoload) is set, new prescaler, period and duty values stay inactive until the period counter wraps to zero.
- R8: When autoload is clear, a new prescaler, period or duty value becomes active on the edge where its transfer completes.
- R9: When a control transfer completes with bit 4 set, the holding prescaler becomes active on that edge. With bit 5 set, the holding period and duty become active on that edge. Both work regardless of autoload.
- R10: Clearing control bit 0 (enable) while bit 3 is clear lets the current period finish. The output parks at its inactive level on the edge where the counter wraps.
- R11: Clearing enable while bit 3 (stop immediately) is set halts the counter and parks the output on the first edge after the control transfer completes.
- R12: A channel starts on the first edge after its holding control word shows enable. It starts with zero counts and loads its active values from the holding copies. The output is therefore valid on the third edge after the enabling write.
- R13: After reset, all holding copies, all busy flags and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for all logic and the PWM time base |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 7 | Byte address of the register access; bits 1:0 are ignored |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| pwm_o | output | 2 | One PWM output per channel |

## Verification
The bench builds the block with its default parameters: two channels, a 10-bit prescaler, a 12-bit period and a two-cycle transfer delay. With these values the status field of channel 1 lands at bits 11:8, and the empty windows 0x20 and 0x30 exist to probe. Small prescaler and period values keep each output period short, so whole periods on both channels are counted exactly. The fixed two-cycle delay lets the bench know the start edge and the counter phase. It can then check autoload, the load strobes and both stop modes on exact cycles.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int CTRL_W     = 6;
  localparam int SLOT_N     = 4;
  localparam int STATUS_OFS = 'h40;
  localparam int FIELD_STEP = 8;

  // register slot inside a channel window, also the status bit order
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_PRE  = 1;
  localparam int SLOT_PER  = 2;
  localparam int SLOT_DUTY = 3;

  // control word bit positions
  localparam int CB_EN    = 0;
  localparam int CB_INV   = 1;
  localparam int CB_AUTO  = 2;
  localparam int CB_STOP  = 3;
  localparam int CB_LDPRE = 4;
  localparam int CB_LDPER = 5;
endpackage

// File: rtl/pwm2_xfer.sv
module pwm2_xfer #(
  parameter int W   = 12,
  parameter int DLY = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] stage_o,
  output logic [W-1:0] hold_o
);
  localparam int CW = $clog2(DLY + 1);

  logic [W-1:0]  stage_q, stage_d, hold_q, hold_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, done;

  always_comb begin
    done    = busy_q && (cnt_q == CW'(1));
    stage_d = stage_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    hold_d  = done ? stage_q : hold_q;
    if (we_i) begin
      stage_d = wdata_i;
      cnt_d   = CW'(DLY);
      busy_d  = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q - CW'(1);
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      hold_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      hold_q  <= hold_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done;
  assign stage_o = stage_q;
  assign hold_o  = hold_q;

  assert_busy_on_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> busy_q);
  assert_hold_moves_when_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hold_q) |-> $past(busy_q));
endmodule

// File: rtl/pwm2_core.sv
module pwm2_core
  import pwm2_pkg::*;
#(
  parameter int PRE_W = 10,
  parameter int PER_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              ctrl_done_i,
  input  logic [CTRL_W-1:0] ctrl_stage_i,
  input  logic              pre_done_i,
  input  logic [PRE_W-1:0]  pre_stage_i,
  input  logic [PRE_W-1:0]  pre_hold_i,
  input  logic              per_done_i,
  input  logic [PER_W-1:0]  per_stage_i,
  input  logic [PER_W-1:0]  per_hold_i,
  input  logic              duty_done_i,
  input  logic [PER_W-1:0]  duty_stage_i,
  input  logic [PER_W-1:0]  duty_hold_i,
  output logic              pwm_o
);
  logic             run_q, run_d;
  logic [PRE_W-1:0] pre_cnt_q, pre_cnt_d, act_pre_q, act_pre_d, pre_nx;
  logic [PER_W-1:0] per_cnt_q, per_cnt_d, act_per_q, act_per_d, per_nx;
  logic [PER_W-1:0] act_duty_q, act_duty_d, duty_nx;
  logic             en, inv, auto_ld, stop_now, tick, wrap;
  logic             unused_ctrl;

  assign unused_ctrl = ^{ctrl_stage_i[CB_STOP:CB_EN], ctrl_i[CB_LDPER:CB_LDPRE]};

  always_comb begin
    en       = ctrl_i[CB_EN];
    inv      = ctrl_i[CB_INV];
    auto_ld  = ctrl_i[CB_AUTO];
    stop_now = ctrl_i[CB_STOP];
    pre_nx   = pre_done_i  ? pre_stage_i  : pre_hold_i;
    per_nx   = per_done_i  ? per_stage_i  : per_hold_i;
    duty_nx  = duty_done_i ? duty_stage_i : duty_hold_i;
    tick     = run_q && (pre_cnt_q >= act_pre_q);
    wrap     = tick && (per_cnt_q >= act_per_q);

    run_d      = run_q;
    pre_cnt_d  = pre_cnt_q;
    per_cnt_d  = per_cnt_q;
    act_pre_d  = act_pre_q;
    act_per_d  = act_per_q;
    act_duty_d = act_duty_q;

    if (!run_q) begin
      if (en) begin
        run_d      = 1'b1;
        pre_cnt_d  = '0;
        per_cnt_d  = '0;
        act_pre_d  = pre_nx;
        act_per_d  = per_nx;
        act_duty_d = duty_nx;
      end
    end else begin
      if (!en && stop_now) begin
        run_d     = 1'b0;
        pre_cnt_d = '0;
        per_cnt_d = '0;
      end else begin
        pre_cnt_d = tick ? '0 : pre_cnt_q + PRE_W'(1);
        if (tick) per_cnt_d = wrap ? '0 : per_cnt_q + PER_W'(1);
        if (wrap && !en) run_d = 1'b0;
      end
      if (auto_ld) begin
        if (wrap) begin
          act_pre_d  = pre_nx;
          act_per_d  = per_nx;
          act_duty_d = duty_nx;
        end
      end else begin
        if (pre_done_i)  act_pre_d  = pre_stage_i;
        if (per_done_i)  act_per_d  = per_stage_i;
        if (duty_done_i) act_duty_d = duty_stage_i;
      end
      if (ctrl_done_i && ctrl_stage_i[CB_LDPRE]) act_pre_d = pre_nx;
      if (ctrl_done_i && ctrl_stage_i[CB_LDPER]) begin
        act_per_d  = per_nx;
        act_duty_d = duty_nx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      pre_cnt_q  <= '0;
      per_cnt_q  <= '0;
      act_pre_q  <= '0;
      act_per_q  <= '0;
      act_duty_q <= '0;
    end else begin
      run_q      <= run_d;
      pre_cnt_q  <= pre_cnt_d;
      per_cnt_q  <= per_cnt_d;
      act_pre_q  <= act_pre_d;
      act_per_q  <= act_per_d;
      act_duty_q <= act_duty_d;
    end
  end

  assign pwm_o = (run_q && (per_cnt_q < act_duty_q)) ^ inv;

  assert_start_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (pre_cnt_q == '0) && (per_cnt_q == '0));
  assert_graceful_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !en && !stop_now && !wrap) |=> run_q);
  assert_stop_imm_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !en && stop_now) |=> !run_q);
endmodule

// File: rtl/pwm2_top.sv
module pwm2_top
  import pwm2_pkg::*;
#(
  parameter int N_CH     = 2,
  parameter int PRE_W    = 10,
  parameter int PER_W    = 12,
  parameter int SYNC_DLY = 2,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   pwm_o
);
  localparam int WIN_W = ADDR_W - 4;

  logic [1:0]             rst_sync_q;
  logic                   rst_n;
  logic [N_CH-1:0]        hit, wr_sel;
  logic [1:0]             slot;
  logic                   is_status;
  logic [N_CH*DATA_W-1:0] ch_rd;
  logic [DATA_W-1:0]      status;
  logic [N_CH*SLOT_N-1:0] busy_all;
  logic                   unused_bus;

  assign unused_bus = ^{addr_i[1:0], wdata_i[DATA_W-1:PER_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign slot      = addr_i[3:2];
  assign is_status = (addr_i == ADDR_W'(STATUS_OFS));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic              ctrl_done, pre_done, per_done, duty_done;
    logic [CTRL_W-1:0] ctrl_stage, ctrl_hold;
    logic [PRE_W-1:0]  pre_stage, pre_hold;
    logic [PER_W-1:0]  per_stage, per_hold, duty_stage, duty_hold;
    logic [SLOT_N-1:0] busy;
    logic [DATA_W-1:0] rd;

    assign hit[c]    = (addr_i[ADDR_W-1:4] == WIN_W'(c));
    assign wr_sel[c] = we_i && hit[c];

    pwm2_xfer #(.W(CTRL_W), .DLY(SYNC_DLY)) u_ctrl (
      .clk_i, .rst_ni(rst_n), .we_i(wr_sel[c] && slot == 2'(SLOT_CTRL)),
      .wdata_i(wdata_i[CTRL_W-1:0]), .busy_o(busy[SLOT_CTRL]), .done_o(ctrl_done),
      .stage_o(ctrl_stage), .hold_o(ctrl_hold));
    pwm2_xfer #(.W(PRE_W), .DLY(SYNC_DLY)) u_pre (
      .clk_i, .rst_ni(rst_n), .we_i(wr_sel[c] && slot == 2'(SLOT_PRE)),
      .wdata_i(wdata_i[PRE_W-1:0]), .busy_o(busy[SLOT_PRE]), .done_o(pre_done),
      .stage_o(pre_stage), .hold_o(pre_hold));
    pwm2_xfer #(.W(PER_W), .DLY(SYNC_DLY)) u_per (
      .clk_i, .rst_ni(rst_n), .we_i(wr_sel[c] && slot == 2'(SLOT_PER)),
      .wdata_i(wdata_i[PER_W-1:0]), .busy_o(busy[SLOT_PER]), .done_o(per_done),
      .stage_o(per_stage), .hold_o(per_hold));
    pwm2_xfer #(.W(PER_W), .DLY(SYNC_DLY)) u_duty (
      .clk_i, .rst_ni(rst_n), .we_i(wr_sel[c] && slot == 2'(SLOT_DUTY)),
      .wdata_i(wdata_i[PER_W-1:0]), .busy_o(busy[SLOT_DUTY]), .done_o(duty_done),
      .stage_o(duty_stage), .hold_o(duty_hold));

    pwm2_core #(.PRE_W(PRE_W), .PER_W(PER_W)) u_core (
      .clk_i, .rst_ni(rst_n),
      .ctrl_i(ctrl_hold), .ctrl_done_i(ctrl_done), .ctrl_stage_i(ctrl_stage),
      .pre_done_i(pre_done), .pre_stage_i(pre_stage), .pre_hold_i(pre_hold),
      .per_done_i(per_done), .per_stage_i(per_stage), .per_hold_i(per_hold),
      .duty_done_i(duty_done), .duty_stage_i(duty_stage), .duty_hold_i(duty_hold),
      .pwm_o(pwm_o[c]));

    always_comb begin
      case (slot)
        2'(SLOT_CTRL): rd = DATA_W'(ctrl_hold);
        2'(SLOT_PRE):  rd = DATA_W'(pre_hold);
        2'(SLOT_PER):  rd = DATA_W'(per_hold);
        default:       rd = DATA_W'(duty_hold);
      endcase
    end
    assign ch_rd[c*DATA_W +: DATA_W]    = rd;
    assign busy_all[c*SLOT_N +: SLOT_N] = busy;
  end

  always_comb begin
    status = '0;
    for (int c = 0; c < N_CH; c++)
      status[c*FIELD_STEP +: SLOT_N] = busy_all[c*SLOT_N +: SLOT_N];
  end

  always_comb begin
    rdata_o = is_status ? status : '0;
    for (int c = 0; c < N_CH; c++)
      if (hit[c]) rdata_o = ch_rd[c*DATA_W +: DATA_W];
  end

  assert_wsel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(wr_sel));
endmodule

// File: tb/pwm2_top_tb_top.sv
module pwm2_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [6:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  pwm;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  pwm2_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm));

  // ch, pre, per, duty, inv, expected high cycles per period
  localparam logic [79:0] VEC [6] = '{
    {8'd0, 16'd0, 16'd9, 16'd3, 8'd0, 16'd3},
    {8'd1, 16'd1, 16'd4, 16'd2, 8'd0, 16'd4},
    {8'd0, 16'd2, 16'd3, 16'd0, 8'd0, 16'd0},
    {8'd1, 16'd0, 16'd7, 16'd8, 8'd0, 16'd8},
    {8'd0, 16'd0, 16'd7, 16'd3, 8'd1, 16'd5},
    {8'd1, 16'd3, 16'd2, 16'd1, 8'd0, 16'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic count_hi(input int ch, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm[ch]) h++;
      @(negedge clk);
    end
  endtask

  // program channel 0 and enable it; returns on the second negedge after the enabling write
  task automatic start0(input int pre, input int per, input int duty, input logic [31:0] ctrl);
    wr(7'h00, 32'h8);
    waitn(4);
    wr(7'h04, pre);
    wr(7'h08, per);
    wr(7'h0C, duty);
    waitn(3);
    wr(7'h00, ctrl);
    waitn(2);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int h;
    rst_ni = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    waitn(3);
    rst_ni = 1'b1;
    waitn(3);

    // R13 reset state
    chk("R13 pwm", {30'd0, pwm}, 32'd0);
    rd(7'h40, v); chk("R13 status", v, 32'd0);
    rd(7'h00, v); chk("R13 ctrl", v, 32'd0);
    rd(7'h1C, v); chk("R13 duty1", v, 32'd0);

    // R2 staging timing, R3 status bit position
    wr(7'h08, 32'h123);
    rd(7'h40, v); chk("R2 busy set", v, 32'h4);
    rd(7'h08, v); chk("R2 old value", v, 32'h0);
    waitn(1);
    rd(7'h40, v); chk("R2 busy held", v, 32'h4);
    waitn(1);
    rd(7'h40, v); chk("R2 busy clear", v, 32'h0);
    rd(7'h08, v); chk("R2 new value", v, 32'h123);

    // R1 width masking
    wr(7'h04, 32'hFFFF_FFFF);
    waitn(2);
    rd(7'h04, v); chk("R1 pre mask", v, 32'h3FF);

    // R3 channel 1 field and read-only status
    wr(7'h1C, 32'h5);
    rd(7'h40, v); chk("R3 ch1 duty busy", v, 32'h800);
    waitn(2);
    rd(7'h1C, v); chk("R1 ch1 duty", v, 32'h5);
    wr(7'h40, 32'hFFFF_FFFF);
    rd(7'h40, v); chk("R3 status write ignored", v, 32'h0);

    // R4 unimplemented windows
    wr(7'h28, 32'h55);
    rd(7'h40, v); chk("R4 no busy", v, 32'h0);
    waitn(2);
    rd(7'h28, v); chk("R4 ch2 reads zero", v, 32'h0);
    wr(7'h30, 32'h7);
    waitn(2);
    rd(7'h30, v); chk("R4 ch3 reads zero", v, 32'h0);
    rd(7'h48, v); chk("R4 above status", v, 32'h0);

    // R5 / R6 waveform vectors
    for (int i = 0; i < 6; i++) begin
      logic [6:0] base;
      int pre, per, duty, len;
      base = 7'(VEC[i][79:72] * 16);
      pre  = int'(VEC[i][71:56]);
      per  = int'(VEC[i][55:40]);
      duty = int'(VEC[i][39:24]);
      len  = (pre + 1) * (per + 1);
      wr(base, 32'h8);
      waitn(4);
      wr(base + 7'h4, pre);
      wr(base + 7'h8, per);
      wr(base + 7'hC, duty);
      waitn(3);
      wr(base, VEC[i][16] ? 32'h3 : 32'h1);
      waitn(3);
      count_hi(int'(VEC[i][72]), 2 * len, h);
      chk(VEC[i][16] ? "R6 inverted high count" : "R5 high count", h, 2 * int'(VEC[i][15:0]));
    end

    // R7 autoload defers duty change
    start0(0, 9, 3, 32'h5);
    waitn(3);                      // counter 2
    wr(7'h0C, 32'd7);              // transfer on edge of counter 5
    waitn(2);
    chk("R7 old duty kept", {31'd0, pwm[0]}, 32'd0);
    waitn(5);
    count_hi(0, 10, h);
    chk("R7 new duty after wrap", h, 32'd7);

    // R8 immediate update
    start0(0, 9, 3, 32'h1);
    waitn(3);
    wr(7'h0C, 32'd7);
    waitn(2);
    chk("R8 new duty at once", {31'd0, pwm[0]}, 32'd1);

    // R9 load-period strobe under autoload
    start0(0, 9, 3, 32'h5);
    waitn(1);                      // counter 0
    wr(7'h0C, 32'd7);
    waitn(2);
    wr(7'h00, 32'h25);
    waitn(1);
    chk("R9 before strobe", {31'd0, pwm[0]}, 32'd0);
    waitn(1);
    chk("R9 strobe loads duty", {31'd0, pwm[0]}, 32'd1);

    // R12 start edge, R10 graceful stop
    start0(0, 9, 10, 32'h1);
    chk("R12 not yet running", {31'd0, pwm[0]}, 32'd0);
    waitn(1);
    chk("R12 running", {31'd0, pwm[0]}, 32'd1);
    wr(7'h00, 32'h0);
    waitn(8);
    chk("R10 period finishes", {31'd0, pwm[0]}, 32'd1);
    waitn(1);
    chk("R10 parked at wrap", {31'd0, pwm[0]}, 32'd0);
    waitn(1);
    chk("R10 stays parked", {31'd0, pwm[0]}, 32'd0);

    // R11 immediate stop
    start0(0, 9, 10, 32'h1);
    waitn(1);
    wr(7'h00, 32'h8);
    waitn(2);
    chk("R11 still running", {31'd0, pwm[0]}, 32'd1);
    waitn(1);
    chk("R11 halted", {31'd0, pwm[0]}, 32'd0);

    // R6 inverted park level
    start0(0, 9, 10, 32'h3);
    waitn(1);
    wr(7'h00, 32'hA);
    waitn(2);
    chk("R6 inverted running", {31'd0, pwm[0]}, 32'd0);
    waitn(1);
    chk("R6 inverted park", {31'd0, pwm[0]}, 32'd1);

    finish_run();
  end
endmodule